// File: doc/BRIEF.md
# Cache and Translation Control Register Bank

This block holds the software-visible control and status words for a processor's cache and address-translation hardware. A small synchronous register bus carries the traffic: a byte address, a write enable with 32-bit write data, and a read enable with 32-bit read data. Each stored word keeps only the bits that its own writable mask allows. The other bits read back as zero.

Some control bits are commands, not state. Writing them raises a single-cycle strobe toward the translation buffer or the caches, and the bit itself is never stored. Four conditions raise strobes:

- a full translation-buffer flush;
- an instruction-cache invalidate;
- an operand-cache invalidate;
- an address-space flush, which fires only when the address-space identifier actually takes a new value.

A change of the translation-enable bit also raises a mode-change strobe. Any write to either store-queue area word raises a configuration-change strobe. The caches, the translation buffer and the page walker sit outside this block. They consume the strobes.

Two words are read-only constants: an identification word and a product word. A synchronous warm-reset input returns the translation-control and cache-control words to zero and sets the exception-event word to its warm value. The asynchronous power-on reset clears everything.

Top module: `mmu_cache_regbank`

## Requirements
- R1: A write to a read-write word stores `wr_data` ANDed with that word's storage mask, and a later read returns exactly that value. The storage masks, by byte offset, are:
  - 0x00: 0xFFFFFCFF
  - 0x04: 0x1FFFFDFF
  - 0x08: 0xFFFFFFFF
  - 0x0C: 0xFFFFFFFF
  - 0x10: 0xFCFCFF01
  - 0x1C: 0x000081A7
  - 0x20: 0x000003FC
  - 0x24: 0x00000FFF
  - 0x28: 0x00000FFF
  - 0x34: 0x0000000F
  - 0x38: 0x0000001C
  - 0x3C: 0x0000001C
- R2: The two break identifier words at offsets 0x14 and 0x18 keep only `wr_data[7:0]`. Bits 31:8 always read 0.
- R3: A write to offset 0x00 raises `asid_flush` for exactly one cycle, one cycle after the write, when `wr_data[7:0]` differs from the stored identifier in bits 7:0. A write that keeps the same identifier raises no strobe.
- R4: A write to offset 0x10 with bit 2 set raises `tlb_flush_all` for one cycle. Bit 2 always reads back as 0.
- R5: A write to offset 0x10 whose bit 0 differs from the stored bit 0 raises `xlat_mode_chg` for one cycle.
- R6: A write to offset 0x1C with bit 11 set raises `icache_inv` for one cycle. A write to that offset with bit 3 set raises `ocache_inv` for one cycle. Both bits read back as 0.
- R7: Offset 0x30 always reads 0x040205C1 and offset 0x44 always reads 0. Writes to both offsets have no effect.
- R8: After power-on reset every word reads 0, except offset 0x30, and every strobe is low. A one-cycle warm reset clears offsets 0x10 and 0x1C, sets offset 0x24 to 0x20, and leaves all other words unchanged.
- R9: Any write to offset 0x38 or 0x3C raises `sq_cfg_chg` for one cycle.
- R10: Reads of unmapped offsets return 0. An address with nonzero bits 1:0 counts as unmapped. Writes to unmapped offsets change no word and raise no strobe. Unmapped offsets are 0x2C, 0x40, everything from 0x48 up, and any misaligned address.
- R11: `rd_data` updates on the clock edge that samples `rd_en` high. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable |
| rd_data | output | DATA_W | Registered read data |
| asid_flush | output | 1 | Address-space flush strobe |
| tlb_flush_all | output | 1 | Full translation-buffer flush strobe |
| xlat_mode_chg | output | 1 | Translation-enable change strobe |
| icache_inv | output | 1 | Instruction-cache invalidate strobe |
| ocache_inv | output | 1 | Operand-cache invalidate strobe |
| sq_cfg_chg | output | 1 | Store-queue configuration change strobe |

## Verification
The hardest case to reach is the address-space flush decision. It depends on the stored identifier, not only on the incoming write, so a strobe is wrong whenever the stored state is wrong. The stimulus therefore writes the page-table-high word several times in a row:

- with a new identifier;
- with the same identifier but different upper bits;
- with a misaligned alias of the same offset.

The bench keeps its own model of every stored word, so each expected strobe pattern follows from the write history. The same model covers the translation-enable toggle and the warm reset that lands between writes.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

   localparam int unsigned SLOT_COUNT = 18;
   localparam int unsigned WORD_W     = 32;

   localparam int unsigned IDX_PTEH   = 0;
   localparam int unsigned IDX_MMUCR  = 4;
   localparam int unsigned IDX_CCR    = 7;
   localparam int unsigned IDX_EXPEVT = 9;
   localparam int unsigned IDX_VER    = 12;
   localparam int unsigned IDX_SQA0   = 14;
   localparam int unsigned IDX_SQA1   = 15;
   localparam int unsigned IDX_PRODID = 17;

   localparam int unsigned ASID_LSB = 0;
   localparam int unsigned ASID_W   = 8;
   localparam int unsigned AT_BIT   = 0;
   localparam int unsigned TI_BIT   = 2;
   localparam int unsigned OCI_BIT  = 3;
   localparam int unsigned ICI_BIT  = 11;

   typedef enum logic [1:0] {SK_NONE, SK_RW, SK_CONST} slot_kind_e;

   typedef struct packed {
      logic asid_flush;
      logic tlb_flush;
      logic mode_chg;
      logic icache_inv;
      logic ocache_inv;
      logic sq_chg;
   } strobe_t;

   function automatic slot_kind_e slot_kind(int unsigned i);
      if (i >= SLOT_COUNT)            return SK_NONE;
      if (i == 11 || i == 16)         return SK_NONE;
      if (i == IDX_VER || i == IDX_PRODID) return SK_CONST;
      return SK_RW;
   endfunction

   // Storage masks: command bits (TI, ICI, OCI) are excluded, they never persist.
   function automatic logic [WORD_W-1:0] store_mask(int unsigned i);
      case (i)
         0:       return 32'hFFFF_FCFF;
         1:       return 32'h1FFF_FDFF;
         2, 3:    return 32'hFFFF_FFFF;
         4:       return 32'hFCFC_FF05 & ~(32'h1 << TI_BIT);
         5, 6:    return 32'h0000_00FF;
         7:       return 32'h0000_89AF & ~(32'h1 << ICI_BIT) & ~(32'h1 << OCI_BIT);
         8:       return 32'h0000_03FC;
         9, 10:   return 32'h0000_0FFF;
         13:      return 32'h0000_000F;
         14, 15:  return 32'h0000_001C;
         default: return 32'h0;
      endcase
   endfunction

endpackage

// File: rtl/mcr_decode.sv
module mcr_decode
   import mcr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   localparam int unsigned IDX_W = ADDR_W - 2
)(
   input  logic [ADDR_W-1:0]     addr,
   output logic [IDX_W-1:0]      idx,
   output logic                  hit,
   output logic [SLOT_COUNT-1:0] sel
);

   assign idx = addr[ADDR_W-1:2];
   assign hit = (addr[1:0] == 2'b00) && (idx < IDX_W'(SLOT_COUNT));

   generate
      for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_sel
         assign sel[g] = hit && (idx == IDX_W'(g));
      end
   endgenerate

endmodule

// File: rtl/mcr_cmd.sv
module mcr_cmd
   import mcr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_eff,
   input  logic              hit_pteh,
   input  logic              hit_mmucr,
   input  logic              hit_ccr,
   input  logic              hit_sq,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              wr_at,
   input  logic              cur_at,
   input  logic              wr_ti,
   input  logic              wr_ici,
   input  logic              wr_oci,
   output strobe_t           stb
);

   strobe_t stb_d;

   always_comb begin
      stb_d            = '0;
      stb_d.asid_flush = wr_eff && hit_pteh && (wr_asid != cur_asid);
      stb_d.tlb_flush  = wr_eff && hit_mmucr && wr_ti;
      stb_d.mode_chg   = wr_eff && hit_mmucr && (wr_at != cur_at);
      stb_d.icache_inv = wr_eff && hit_ccr && wr_ici;
      stb_d.ocache_inv = wr_eff && hit_ccr && wr_oci;
      stb_d.sq_chg     = wr_eff && hit_sq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb <= '0;
      else        stb <= stb_d;
   end

endmodule

// File: rtl/mcr_rdmux.sv
module mcr_rdmux
   import mcr_pkg::*;
#(
   parameter int unsigned IDX_W         = 6,
   parameter logic [31:0] VERSION_ID    = 32'h0402_05C1,
   parameter bit          RD_REGISTERED = 1'b1
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_en,
   input  logic                         hit,
   input  logic [IDX_W-1:0]             idx,
   input  logic [SLOT_COUNT*WORD_W-1:0] flat,
   output logic [WORD_W-1:0]            rd_data
);

   logic [WORD_W-1:0] word;

   always_comb begin
      word = '0;
      for (int i = 0; i < SLOT_COUNT; i++) begin
         if (hit && idx == IDX_W'(i)) word = flat[i*WORD_W +: WORD_W];
      end
   end

   generate
      if (RD_REGISTERED) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_data <= '0;
            else if (rd_en) rd_data <= word;
         end

         p_version_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_en && hit && idx == IDX_W'(IDX_VER)) |-> rd_data == VERSION_ID)
            else $error("identification word read wrong");

         p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_en && !hit) |-> rd_data == '0)
            else $error("unmapped read not zero");

         p_ti_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_en && hit && idx == IDX_W'(IDX_MMUCR)) |-> !rd_data[TI_BIT])
            else $error("flush command bit read back set");
      end else begin : g_rd_comb
         assign rd_data = rd_en ? word : '0;
      end
   endgenerate

endmodule

// File: rtl/mmu_cache_regbank.sv
module mmu_cache_regbank
   import mcr_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 32,
   parameter logic [31:0] VERSION_ID    = 32'h0402_05C1,
   parameter logic [31:0] WARM_EXC_CODE = 32'h0000_0020,
   parameter bit          RD_REGISTERED = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              warm_rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              asid_flush,
   output logic              tlb_flush_all,
   output logic              xlat_mode_chg,
   output logic              icache_inv,
   output logic              ocache_inv,
   output logic              sq_cfg_chg
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   generate
      if (DATA_W != WORD_W) begin : g_bad_data_w
         $error("DATA_W must equal 32");
      end
      if (ADDR_W < 7) begin : g_bad_addr_w
         $error("ADDR_W too small to reach every mapped word");
      end
   endgenerate

   logic [IDX_W-1:0]             idx;
   logic                         hit;
   logic [SLOT_COUNT-1:0]        sel;
   logic                         wr_eff;
   logic [SLOT_COUNT*WORD_W-1:0] flat;
   strobe_t                      stb;

   assign wr_eff = wr_en && !warm_rst;

   mcr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .idx  (idx),
      .hit  (hit),
      .sel  (sel)
   );

   generate
      for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_slot
         localparam slot_kind_e KIND = slot_kind(g);
         if (KIND == SK_RW) begin : g_rw
            localparam logic [WORD_W-1:0] MASK = store_mask(g);
            localparam bit WARM_HIT = (g == IDX_MMUCR) || (g == IDX_CCR) || (g == IDX_EXPEVT);
            localparam logic [WORD_W-1:0] WARM_VAL = (g == IDX_EXPEVT) ? WARM_EXC_CODE : '0;
            logic [WORD_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                  q <= '0;
               else if (warm_rst && WARM_HIT) q <= WARM_VAL;
               else if (wr_eff && sel[g])   q <= wr_data & MASK;
            end
            assign flat[g*WORD_W +: WORD_W] = q;
         end else if (KIND == SK_CONST) begin : g_const
            assign flat[g*WORD_W +: WORD_W] = (g == IDX_VER) ? VERSION_ID : '0;
         end else begin : g_hole
            assign flat[g*WORD_W +: WORD_W] = '0;
         end
      end
   endgenerate

   logic [ASID_W-1:0] cur_asid;
   logic              cur_at;
   logic [WORD_W-1:0] mmucr_word, ccr_word, exc_word;

   assign cur_asid   = flat[IDX_PTEH*WORD_W + ASID_LSB +: ASID_W];
   assign cur_at     = flat[IDX_MMUCR*WORD_W + AT_BIT];
   assign mmucr_word = flat[IDX_MMUCR*WORD_W +: WORD_W];
   assign ccr_word   = flat[IDX_CCR*WORD_W +: WORD_W];
   assign exc_word   = flat[IDX_EXPEVT*WORD_W +: WORD_W];

   mcr_cmd u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_eff    (wr_eff),
      .hit_pteh  (sel[IDX_PTEH]),
      .hit_mmucr (sel[IDX_MMUCR]),
      .hit_ccr   (sel[IDX_CCR]),
      .hit_sq    (sel[IDX_SQA0] || sel[IDX_SQA1]),
      .wr_asid   (wr_data[ASID_LSB +: ASID_W]),
      .cur_asid  (cur_asid),
      .wr_at     (wr_data[AT_BIT]),
      .cur_at    (cur_at),
      .wr_ti     (wr_data[TI_BIT]),
      .wr_ici    (wr_data[ICI_BIT]),
      .wr_oci    (wr_data[OCI_BIT]),
      .stb       (stb)
   );

   mcr_rdmux #(
      .IDX_W         (IDX_W),
      .VERSION_ID    (VERSION_ID),
      .RD_REGISTERED (RD_REGISTERED)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .hit     (hit),
      .idx     (idx),
      .flat    (flat),
      .rd_data (rd_data)
   );

   assign asid_flush    = stb.asid_flush;
   assign tlb_flush_all = stb.tlb_flush;
   assign xlat_mode_chg = stb.mode_chg;
   assign icache_inv    = stb.icache_inv;
   assign ocache_inv    = stb.ocache_inv;
   assign sq_cfg_chg    = stb.sq_chg;

   p_asid_changed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      asid_flush |-> cur_asid != $past(cur_asid))
      else $error("address-space flush without identifier change");

   p_at_changed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_mode_chg |-> cur_at != $past(cur_at))
      else $error("mode strobe without enable change");

   p_warm_values_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(warm_rst) |-> (mmucr_word == '0 && ccr_word == '0 && exc_word == WARM_EXC_CODE))
      else $error("warm reset values wrong");

endmodule

// File: tb/sim_mmu_cache_regbank.sv
module sim_mmu_cache_regbank;

   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] VER        = 32'h0402_05C1;
   localparam int          WDOG_LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        warm_rst = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        asid_flush, tlb_flush_all, xlat_mode_chg, icache_inv, ocache_inv, sq_cfg_chg;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [31:0] mdl [18];
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_seen = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmu_cache_regbank u0 (
      .clk (clk), .rst_n (rst_n), .warm_rst (warm_rst), .addr (addr),
      .wr_en (wr_en), .wr_data (wr_data), .rd_en (rd_en), .rd_data (rd_data),
      .asid_flush (asid_flush), .tlb_flush_all (tlb_flush_all),
      .xlat_mode_chg (xlat_mode_chg), .icache_inv (icache_inv),
      .ocache_inv (ocache_inv), .sq_cfg_chg (sq_cfg_chg)
   );

   function automatic bit is_rw(int i);
      return i < 18 && i != 11 && i != 12 && i != 16 && i != 17;
   endfunction

   function automatic logic [31:0] bmask(int i);
      case (i)
         0: return 32'hFFFFFCFF;   1: return 32'h1FFFFDFF;
         2, 3: return 32'hFFFFFFFF;
         4: return 32'hFCFCFF05 & ~32'h4;
         5, 6: return 32'hFF;
         7: return 32'h89AF & ~32'h808;
         8: return 32'h3FC;        9, 10: return 32'hFFF;
         13: return 32'hF;         14, 15: return 32'h1C;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] strobes();
      return {asid_flush, tlb_flush_all, xlat_mode_chg, icache_inv, ocache_inv, sq_cfg_chg};
   endfunction

   // Driver: write with model-predicted strobe pattern
   task automatic do_write(logic [7:0] a, logic [31:0] d, string req);
      int i = int'(a >> 2);
      logic [5:0] es = '0;
      if (a[1:0] == 2'b00 && is_rw(i)) begin
         if (i == 0)  es[5] = (d[7:0] != mdl[0][7:0]);
         if (i == 4)  begin es[4] = d[2]; es[3] = (d[0] != mdl[4][0]); end
         if (i == 7)  begin es[2] = d[11]; es[1] = d[3]; end
         if (i == 14 || i == 15) es[0] = 1'b1;
         mdl[i] = d & bmask(i);
      end
      @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      check(req, {26'h0, strobes()}, {26'h0, es});
      @(negedge clk);
      check(req, {26'h0, strobes()}, 32'h0);
   endtask

   // Driver: read, expected value pushed to the scoreboard
   task automatic do_read(logic [7:0] a, string req);
      int i = int'(a >> 2);
      logic [31:0] e = '0;
      if (a[1:0] == 2'b00 && is_rw(i)) e = mdl[i];
      else if (a == 8'h30)            e = VER;
      @(negedge clk); addr = a; rd_en = 1'b1;
      exp_q.push_back(e); tag_q.push_back(req);
      @(negedge clk); rd_en = 1'b0;
   endtask

   // Monitor
   always @(posedge clk) rd_seen <= rd_en;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) check("R11", 32'h1, 32'h0);
         else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG_LIMIT && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG_LIMIT);
         summary();
         $finish;
      end
   end

   localparam logic [7:0] RW_OFFS [14] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                            8'h1C, 8'h20, 8'h24, 8'h28, 8'h34, 8'h38, 8'h3C};

   initial begin
      for (int i = 0; i < 18; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: power-on state
      check("R8", {26'h0, strobes()}, 32'h0);
      for (int k = 0; k < 18; k++) do_read(8'(k*4), "R8");

      // R1: masked storage with several patterns
      for (int k = 0; k < 14; k++) begin
         do_write(RW_OFFS[k], 32'hFFFF_FFFF, "R1");
         do_read(RW_OFFS[k], "R1");
         do_write(RW_OFFS[k], 32'hA5A5_5A5A, "R1");
         do_read(RW_OFFS[k], "R1");
      end

      // R2: narrow break identifier words
      do_write(8'h14, 32'hDEAD_BE5A, "R2");
      do_read(8'h14, "R2");
      do_write(8'h18, 32'h1234_56C3, "R2");
      do_read(8'h18, "R2");

      // R3: identifier change vs. same identifier
      do_write(8'h00, 32'h0000_0312, "R3");
      do_write(8'h00, 32'hFFFF_0012, "R3");
      do_write(8'h00, 32'h0000_0013, "R3");
      do_read(8'h00, "R3");

      // R4 / R5: flush command and enable toggling
      do_write(8'h10, 32'h0000_0004, "R4");
      do_read(8'h10, "R4");
      do_write(8'h10, 32'h0000_0005, "R5");
      do_write(8'h10, 32'h0000_0001, "R5");
      do_write(8'h10, 32'h0000_0000, "R5");
      do_read(8'h10, "R5");

      // R6: cache invalidate commands, separately and together
      do_write(8'h1C, 32'h0000_0800, "R6");
      do_write(8'h1C, 32'h0000_0008, "R6");
      do_write(8'h1C, 32'h0000_89AF, "R6");
      do_read(8'h1C, "R6");

      // R9: store-queue words
      do_write(8'h38, 32'h0000_0000, "R9");
      do_write(8'h3C, 32'h0000_0010, "R9");

      // R7: constant words ignore writes
      do_write(8'h30, 32'hFFFF_FFFF, "R7");
      do_write(8'h44, 32'hFFFF_FFFF, "R7");
      do_read(8'h30, "R7");
      do_read(8'h44, "R7");

      // R10: unmapped and misaligned accesses
      do_write(8'h2C, 32'hFFFF_FFFF, "R10");
      do_write(8'h01, 32'h0000_00FF, "R10");
      do_write(8'h40, 32'hFFFF_FFFF, "R10");
      do_read(8'h2C, "R10");
      do_read(8'h40, "R10");
      do_read(8'h48, "R10");
      do_read(8'hFC, "R10");
      do_read(8'h31, "R10");
      do_read(8'h00, "R10");

      // R11: read data holds while rd_en is low
      do_read(8'h30, "R11");
      @(negedge clk); addr = 8'h00;
      @(negedge clk);
      check("R11", rd_data, VER);

      // R8: warm reset
      do_write(8'h10, 32'h0000_0001, "R8");
      do_write(8'h1C, 32'h0000_0001, "R8");
      do_write(8'h24, 32'h0000_0ABC, "R8");
      do_write(8'h08, 32'h0000_1234, "R8");
      @(negedge clk); warm_rst = 1'b1;
      @(negedge clk); warm_rst = 1'b0;
      mdl[4] = '0; mdl[7] = '0; mdl[9] = 32'h20;
      check("R8", {26'h0, strobes()}, 32'h0);
      for (int k = 0; k < 18; k++) do_read(8'(k*4), "R8");

      repeat (3) @(negedge clk);
      check("R11", exp_q.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule